// File: doc/BRIEF.md
# Rotate, Mask and Shift Unit

This block is the single combinational datapath that serves every rotate-with-mask, shift-left, logical shift-right and arithmetic shift-right operation of a 64-bit integer pipeline. It has no clock and no state. Its inputs are:

- a source operand and an insert-target operand;
- a 7-bit shift amount;
- two 6-bit mask-edge fields;
- a 3-bit operation code;
- a word-mode flag and an arithmetic flag.

It returns a 64-bit result and a carry-out.

Every operation goes through the same path. The source is rotated left through three levels of 4:1 multiplexers, which step by 16, by 4 and by 1 bit. Two edge-mask generators build a lower bound and an upper bound. The two bounds are combined into one mask. Bits outside the mask are filled with zeros, with copies of the sign, or with the insert-target operand. In word mode the low 32 bits of the source are copied into both halves before the rotate, so one rotator serves both operand widths.

Bit numbering in this brief counts from the least significant bit, which is bit 0.

Top module: `rms_unit`

## Requirements
- R1: For the rotate forms (codes 0, 1, 2), the rotated value is `src_val` rotated left by `shamt[5:0]` in doubleword mode. In word mode it is `src_val[31:0]` rotated left by `shamt[4:0]`, placed in both halves. This rotated value is ANDed with the mask of the selected form.
- R2: Code 0 (band) keeps bits `edge_lo`..`edge_hi` inclusive. When `edge_lo` > `edge_hi`, the mask wraps: it keeps bits >= `edge_lo` and bits <= `edge_hi`.
- R3: Code 1 keeps bits 0..`edge_hi` and clears everything above. Code 2 keeps bits `edge_lo` up to the top of the operand and clears everything below.
- R4: In word mode only bits [4:0] of each edge field are used. The top of the operand for code 2 is bit 31. A wrapping band mask also keeps the whole upper word.
- R5: With `merge_en` set, a rotate form returns `(rotated AND mask) OR (ins_val AND NOT mask)`.
- R6: Code 3 shifts left and zero-fills. In word mode the upper word is zero. The result is zero when the overflow bit is set: `shamt[6]` in doubleword mode, `shamt[5]` in word mode. In word mode `shamt[6]` is ignored.
- R7: Code 4 with `arith_en` clear is a logical right shift with the same overflow rule as R6. In word mode the upper word of the result is zero.
- R8: Code 4 with `arith_en` set fills the vacated bits with the sign: bit 63, or bit 31 in word mode. In word mode the result is sign-extended to 64 bits. On overflow every bit equals the sign.
- R9: `carry_out` is 1 only for code 4 with `arith_en` set, a negative source, and at least one 1 bit shifted out of the operand. On overflow, every bit of the operand counts as shifted out.
- R10: Inputs are ignored outside their own forms: `merge_en` for the shifts, `arith_en` for every code other than 4, and `src_val[63:32]` for word-mode shifts.
- R11: Codes 5, 6 and 7 give a zero result and a zero carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_val | input | 64 | Operand that is rotated or shifted |
| ins_val | input | 64 | Insert target, placed outside the mask when merging |
| shamt | input | 7 | Shift or rotate amount; the top bit used is the overflow bit |
| edge_hi | input | 6 | Highest kept bit position for the mask |
| edge_lo | input | 6 | Lowest kept bit position for the mask |
| op_sel | input | 3 | Operation code: 0 band, 1 keep-low, 2 keep-high, 3 shift left, 4 shift right |
| word_mode | input | 1 | Selects the 32-bit form |
| arith_en | input | 1 | Selects arithmetic right shift for code 4 |
| merge_en | input | 1 | Enables insert merging for the rotate forms |
| result | output | 64 | Operation result |
| carry_out | output | 1 | Carry from an arithmetic right shift |

## Verification
The block holds no state, so an internal fault shows at the ports as soon as its inputs settle. A wrong select on one rotator level shifts the result by a fixed multiple of 1, 4 or 16 bits. That error only appears at amounts whose matching digit is non-zero, which is why shift amounts are swept across their full range. A wrong mask edge or a wrong wrap decision shows up as single stray bits at the edge positions. A wrong sign or carry choice shows up only with negative sources and non-zero low bits, so those patterns are included in every shift sweep.

// File: rtl/rms_pkg.sv
// Package rms_pkg
// Shared widths and the operation code for the rotate/mask/shift unit.
// Assumes a 64-bit datapath; the code values are fixed by the decoder
// that feeds op_sel.
package rms_pkg;

    localparam int RMS_DATA_W = 64;

    typedef enum logic [2:0] {
        RMS_ROT_BAND = 3'd0,   // keep bits lo..hi (may wrap)
        RMS_ROT_LOW  = 3'd1,   // keep bits 0..hi
        RMS_ROT_HIGH = 3'd2,   // keep bits lo..top
        RMS_SHL      = 3'd3,   // shift left
        RMS_SHR      = 3'd4    // shift right, logical or arithmetic
    } rms_op_e;

endpackage

// File: rtl/rms_rotator.sv
// Module rms_rotator
// Left rotator built from radix-4 levels. The coarsest level is applied first.
// With the defaults there are three levels: steps of 16, 4 and 1 bit.
// Assumes SH_W is even and DATA_W equals 2**SH_W.
module rms_rotator #(
    parameter int DATA_W = 64,
    parameter int SH_W   = 6
) (
    input  logic [DATA_W-1:0] din,
    input  logic [SH_W-1:0]   amt,
    output logic [DATA_W-1:0] dout
);
    localparam int LVLS = SH_W / 2;

    logic [LVLS:0][DATA_W-1:0] lvl;

    // Level 0 is the unrotated input.
    assign lvl[0] = din;

    for (genvar g = 0; g < LVLS; g++) begin : g_lvl
        localparam int DIGIT = LVLS - 1 - g;
        localparam int STEP  = 1 << (2 * DIGIT);
        logic [1:0] sel;
        logic [DATA_W-1:0] r1, r2, r3;

        // Digit of the rotate amount that drives this level.
        assign sel = amt[2*DIGIT +: 2];
        // The three non-trivial rotations offered by this level.
        assign r1 = (lvl[g] << STEP)       | (lvl[g] >> (DATA_W - STEP));
        assign r2 = (lvl[g] << (2 * STEP)) | (lvl[g] >> (DATA_W - 2 * STEP));
        assign r3 = (lvl[g] << (3 * STEP)) | (lvl[g] >> (DATA_W - 3 * STEP));
        // 4:1 selection for this level.
        assign lvl[g+1] = (sel == 2'd0) ? lvl[g] :
                          (sel == 2'd1) ? r1 :
                          (sel == 2'd2) ? r2 : r3;
    end

    assign dout = lvl[LVLS];

    // A zero amount must pass the operand through unchanged.
    always_comb begin
        AST_ROT_IDENTITY: assert (amt != '0 || dout == din) else $error("rotator not identity at zero"); // R1
    end

endmodule

// File: rtl/rms_edge_mask.sv
// Module rms_edge_mask
// Builds a one-sided bit mask from a position.
// With BELOW = 1, bit i is set when i < pos.
// With BELOW = 0, bit i is set when i >= pos.
// pos is one bit wider than a bit index, so the values 0 and DATA_W give
// empty or full masks.
module rms_edge_mask #(
    parameter int DATA_W = 64,
    parameter int POS_W  = 7,
    parameter bit BELOW  = 1'b1
) (
    input  logic [POS_W-1:0]  pos,
    output logic [DATA_W-1:0] mask
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        localparam logic [POS_W-1:0] IDX = POS_W'(i);
        if (BELOW) begin : g_lo
            // Set every bit strictly under the position.
            assign mask[i] = (IDX < pos);
        end else begin : g_hi
            // Set every bit at or over the position.
            assign mask[i] = (IDX >= pos);
        end
    end
endmodule

// File: rtl/rms_unit.sv
// Module rms_unit
// Combinational rotate, mask and shift unit. It has no state.
// The control logic turns op_sel, word_mode and shamt into:
//   - a rotate amount,
//   - two mask edge positions and a wrap decision,
//   - a fill source for the bits outside the mask.
// Assumes op codes above 4 never matter except to yield zero.
module rms_unit
    import rms_pkg::*;
#(
    parameter int DATA_W = RMS_DATA_W
) (
    input  logic [DATA_W-1:0]          src_val,
    input  logic [DATA_W-1:0]          ins_val,
    input  logic [$clog2(DATA_W):0]    shamt,
    input  logic [$clog2(DATA_W)-1:0]  edge_hi,
    input  logic [$clog2(DATA_W)-1:0]  edge_lo,
    input  logic [2:0]                 op_sel,
    input  logic                       word_mode,
    input  logic                       arith_en,
    input  logic                       merge_en,
    output logic [DATA_W-1:0]          result,
    output logic                       carry_out
);
    localparam int SH_W   = $clog2(DATA_W);
    localparam int POS_W  = SH_W + 1;
    localparam int HALF_W = DATA_W / 2;

    rms_op_e             op;
    logic                is_rot, ovf, wrap, sign;
    logic [SH_W-1:0]     sh_eff, rot_amt, hi_eff, lo_eff;
    logic [POS_W-1:0]    lpos, rpos, top_pos;
    logic [DATA_W-1:0]   rot_in, rot_out, lmask, rmask, mask, fill, word_keep;

    assign op = rms_op_e'(op_sel);

    // Operand width handling: fold amounts and edges, and copy the low word into both halves.
    always_comb begin
        is_rot    = (op == RMS_ROT_BAND) || (op == RMS_ROT_LOW) || (op == RMS_ROT_HIGH);
        ovf       = word_mode ? shamt[SH_W-1] : shamt[SH_W];
        sh_eff    = word_mode ? {1'b0, shamt[SH_W-2:0]} : shamt[SH_W-1:0];
        hi_eff    = word_mode ? {1'b0, edge_hi[SH_W-2:0]} : edge_hi;
        lo_eff    = word_mode ? {1'b0, edge_lo[SH_W-2:0]} : edge_lo;
        top_pos   = word_mode ? POS_W'(HALF_W) : POS_W'(DATA_W);
        rot_in    = word_mode ? {src_val[HALF_W-1:0], src_val[HALF_W-1:0]} : src_val;
        word_keep = word_mode ? {{HALF_W{1'b0}}, {HALF_W{1'b1}}} : {DATA_W{1'b1}};
        rot_amt   = (op == RMS_SHR) ? (SH_W'(0) - sh_eff) : sh_eff;
    end

    rms_rotator #(.DATA_W(DATA_W), .SH_W(SH_W)) i_rot (
        .din  (rot_in),
        .amt  (rot_amt),
        .dout (rot_out)
    );

    // Edge positions and the wrap decision for each operation.
    always_comb begin
        lpos = '0;
        rpos = '0;
        wrap = 1'b0;
        case (op)
            RMS_ROT_BAND: begin
                lpos = POS_W'(hi_eff) + POS_W'(1);
                rpos = POS_W'(lo_eff);
                wrap = (lo_eff > hi_eff);
            end
            RMS_ROT_LOW: begin
                lpos = POS_W'(hi_eff) + POS_W'(1);
            end
            RMS_ROT_HIGH: begin
                lpos = top_pos;
                rpos = POS_W'(lo_eff);
            end
            RMS_SHL: begin
                lpos = top_pos;
                rpos = ovf ? POS_W'(DATA_W) : POS_W'(sh_eff);
            end
            RMS_SHR: begin
                lpos = ovf ? '0 : (top_pos - POS_W'(sh_eff));
            end
            default: begin
                lpos = '0;
            end
        endcase
    end

    rms_edge_mask #(.DATA_W(DATA_W), .POS_W(POS_W), .BELOW(1'b1)) i_lmask (
        .pos  (lpos),
        .mask (lmask)
    );

    rms_edge_mask #(.DATA_W(DATA_W), .POS_W(POS_W), .BELOW(1'b0)) i_rmask (
        .pos  (rpos),
        .mask (rmask)
    );

    // Combine the masks, choose the fill and form the result and the carry.
    always_comb begin
        mask      = wrap ? (lmask | rmask) : (lmask & rmask);
        sign      = (op == RMS_SHR) && arith_en &&
                    (word_mode ? src_val[HALF_W-1] : src_val[DATA_W-1]);
        fill      = (merge_en && is_rot) ? ins_val : {DATA_W{sign}};
        result    = (rot_out & mask) | (fill & ~mask);
        carry_out = sign && (|(rot_out & ~mask & word_keep));
    end

    // Port-level checks on the finished result.
    always_comb begin
        AST_SHL_OVF_ZERO: assert (!(op_sel == 3'd3 && (word_mode ? shamt[SH_W-1] : shamt[SH_W])) || result == '0) else $error("shift left overflow not zero"); // R6
        AST_SRL_WORD_HI_ZERO: assert (!(op_sel == 3'd4 && word_mode && !arith_en) || result[DATA_W-1:HALF_W] == '0) else $error("logical word shift upper not zero"); // R7
        AST_CARRY_SRA_ONLY: assert (!carry_out || (op_sel == 3'd4 && arith_en && (word_mode ? src_val[HALF_W-1] : src_val[DATA_W-1]))) else $error("carry outside arithmetic shift"); // R9
        AST_BAD_OP_ZERO: assert (op_sel <= 3'd4 || (result == '0 && !carry_out)) else $error("unused code not zero"); // R11
        AST_KEEP_LOW_TOP_CLEAR: assert (!(op_sel == 3'd1 && !word_mode && !merge_en && edge_hi != {SH_W{1'b1}}) || !result[DATA_W-1]) else $error("keep-low form left top bit"); // R3
    end

endmodule

// File: tb/test_rms_unit.sv
// Bench for rms_unit. Sweeps shift amounts and mask edges over several
// source patterns and compares against an arithmetic reference model.
module test_rms_unit;
    logic        clk = 1'b0;
    logic [63:0] src_val, ins_val, result;
    logic [6:0]  shamt;
    logic [5:0]  edge_hi, edge_lo;
    logic [2:0]  op_sel;
    logic        word_mode, arith_en, merge_en, carry_out;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    localparam logic [63:0] PAT [6] = '{
        64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210,
        64'h8000_0000_0000_0001, 64'h7FFF_FFFF_8000_0000,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_7FFF_FFF0
    };

    rms_unit i_rms_unit (
        .src_val  (src_val),
        .ins_val  (ins_val),
        .shamt    (shamt),
        .edge_hi  (edge_hi),
        .edge_lo  (edge_lo),
        .op_sel   (op_sel),
        .word_mode(word_mode),
        .arith_en (arith_en),
        .merge_en (merge_en),
        .result   (result),
        .carry_out(carry_out)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    function automatic logic [31:0] rotl32(input logic [31:0] w, input int n);
        return (n == 0) ? w : ((w << n) | (w >> (32 - n)));
    endfunction

    // Reference model written from the requirements.
    task automatic ref_calc(input int op, input logic [63:0] a, input logic [63:0] b,
                            input int sh, input int hi, input int lo,
                            input bit w32, input bit sgn, input bit mrg,
                            output logic [63:0] r, output bit c);
        logic [63:0] rot, m;
        logic [31:0] w, r32;
        int n, t, bo, s;
        r = '0; c = 1'b0; m = '0; w = a[31:0];
        if (op <= 2) begin
            if (w32) begin
                n = sh % 32; rot = {rotl32(w, n), rotl32(w, n)}; t = hi % 32; bo = lo % 32;
            end else begin
                n = sh % 64; rot = (n == 0) ? a : ((a << n) | (a >> (64 - n))); t = hi; bo = lo;
            end
            for (int i = 0; i < 64; i++) begin
                if (op == 0) m[i] = (bo <= t) ? (i >= bo && i <= t) : (i >= bo || i <= t);
                else if (op == 1) m[i] = (i <= t);
                else m[i] = (i >= bo) && (i <= (w32 ? 31 : 63));
            end
            r = (rot & m) | (mrg ? (b & ~m) : 64'd0);
        end else if (op == 3) begin
            s = w32 ? sh % 64 : sh;
            if (w32) r = (s >= 32) ? 64'd0 : {32'd0, w << s};
            else     r = (s >= 64) ? 64'd0 : (a << s);
        end else if (op == 4) begin
            s = w32 ? sh % 64 : sh;
            if (w32) begin
                if (!sgn) r = {32'd0, w >> s};
                else begin
                    r32 = (s >= 32) ? {32{w[31]}} : 32'($signed(w) >>> s);
                    r = {{32{r32[31]}}, r32};
                    c = w[31] && ((s >= 32) ? (w != 0) : ((w & ((32'd1 << s) - 32'd1)) != 0));
                end
            end else begin
                if (!sgn) r = a >> s;
                else begin
                    r = (s >= 64) ? {64{a[63]}} : 64'($signed(a) >>> s);
                    c = a[63] && ((s >= 64) ? (a != 0) : ((a & ((64'd1 << s) - 64'd1)) != 0));
                end
            end
        end
    endtask

    // Apply one vector and compare against the given expectation.
    task automatic check(input string tag, input int op, input logic [63:0] a, input logic [63:0] b,
                         input int sh, input int hi, input int lo,
                         input bit w32, input bit sgn, input bit mrg,
                         input logic [63:0] exp_r, input bit exp_c);
        op_sel = 3'(op); src_val = a; ins_val = b; shamt = 7'(sh);
        edge_hi = 6'(hi); edge_lo = 6'(lo); word_mode = w32; arith_en = sgn; merge_en = mrg;
        #2;
        n_run = n_run + 1;
        if (result !== exp_r || carry_out !== exp_c) begin
            n_fail = n_fail + 1;
            $display("FAIL %s op=%0d sh=%0d hi=%0d lo=%0d w32=%0b: actual %h/%0b expected %h/%0b",
                     tag, op, sh, hi, lo, w32, result, carry_out, exp_r, exp_c);
        end
        #1;
    endtask

    // Apply one vector with the expectation taken from the reference model.
    task automatic check_ref(input string tag, input int op, input logic [63:0] a, input logic [63:0] b,
                             input int sh, input int hi, input int lo,
                             input bit w32, input bit sgn, input bit mrg);
        logic [63:0] er;
        bit ec;
        ref_calc(op, a, b, sh, hi, lo, w32, sgn, mrg, er, ec);
        check(tag, op, a, b, sh, hi, lo, w32, sgn, mrg, er, ec);
    endtask

    initial begin
        // Idle inputs give a zero result and no carry (R1).
        check("R1 idle", 0, 64'd0, 64'd0, 0, 0, 0, 0, 0, 0, 64'd0, 0);
        // Directed cases with literal expectations.
        check("R1 rotate8", 1, 64'h0123_4567_89AB_CDEF, 64'd0, 8, 63, 0, 0, 0, 0, 64'h2345_6789_ABCD_EF01, 0);
        check("R2 wrap", 0, '1, 64'd0, 0, 3, 60, 0, 0, 0, 64'hF000_0000_0000_000F, 0);
        check("R4 word band", 0, 64'hFFFF_FFFF_0000_00AB, 64'd0, 4, 7, 0, 1, 0, 0, 64'h0000_0000_0000_00B0, 0);
        check("R4 word wrap", 0, 64'h0000_0000_FFFF_FFFF, 64'd0, 0, 3, 28, 1, 0, 0, 64'hFFFF_FFFF_F000_000F, 0);
        check("R5 merge a", 0, '1, 64'd0, 0, 15, 8, 0, 0, 1, 64'h0000_0000_0000_FF00, 0);
        check("R5 merge b", 0, 64'd0, '1, 0, 15, 8, 0, 0, 1, 64'hFFFF_FFFF_FFFF_00FF, 0);
        check("R8 word sra", 4, 64'h1234_5678_8000_0001, 64'd0, 4, 0, 0, 1, 1, 0, 64'hFFFF_FFFF_F800_0000, 1);
        check("R9 no carry", 4, 64'h8000_0000_0000_0000, 64'd0, 4, 0, 0, 0, 1, 0, 64'hF800_0000_0000_0000, 0);
        check("R6 ovf dword", 3, '1, 64'd0, 64, 0, 0, 0, 0, 0, 64'd0, 0);
        check("R6 ovf word", 3, '1, 64'd0, 32, 0, 0, 1, 0, 0, 64'd0, 0);
        check("R6 word bit6 ignored", 3, 64'd1, 64'd0, 65, 0, 0, 1, 0, 0, 64'd2, 0);
        check("R7 word srl", 4, 64'hFFFF_FFFF_8000_0000, 64'd0, 31, 0, 0, 1, 0, 0, 64'd1, 0);
        check("R10 shl merge ignored", 3, 64'd1, '1, 4, 0, 0, 0, 0, 1, 64'h10, 0);
        check("R10 rot arith ignored", 1, 64'h8000_0000_0000_0000, 64'd0, 0, 63, 0, 0, 1, 0, 64'h8000_0000_0000_0000, 0);
        check("R10 word upper ignored", 4, 64'h8000_0000_0000_0010, 64'd0, 4, 0, 0, 1, 1, 0, 64'd1, 0);
        for (int op = 5; op < 8; op++)
            check("R11 unused code", op, '1, '1, 9, 40, 3, 0, 1, 1, 64'd0, 0);

        // Shift sweeps over every amount, width, kind and pattern (R6 R7 R8 R9 R10).
        for (int p = 0; p < 6; p++)
            for (int w = 0; w < 2; w++)
                for (int sg = 0; sg < 2; sg++)
                    for (int sh = 0; sh < 128; sh++) begin
                        check_ref("R6 shl", 3, PAT[p], ~PAT[p], sh, sh % 64, 63 - sh % 64, w[0], sg[0], sg[0]);
                        check_ref(sg ? "R8 R9 sra" : "R7 srl", 4, PAT[p], ~PAT[p], sh, 0, 0, w[0], sg[0], sg[0]);
                    end

        // Rotate-with-mask sweeps over every edge pair (R1 R2 R3 R4 R5).
        for (int p = 0; p < 2; p++)
            for (int op = 0; op < 3; op++)
                for (int w = 0; w < 2; w++)
                    for (int m = 0; m < 2; m++)
                        for (int hi = 0; hi < 64; hi++)
                            for (int lo = 0; lo < 64; lo++)
                                check_ref(op == 0 ? "R2 band" : (w ? "R4 word" : (m ? "R5 merge" : "R3 edge")),
                                          op, PAT[p + 1], PAT[p + 3], (hi * 7 + lo) % 128, hi, lo, w[0], m[0], m[0]);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule